// File: doc/BRIEF.md
# Output Clock Divider with Gradual Power-Down

The block takes a fast input clock and produces an output clock whose period is set by a two-bit ratio code. The output always has a 50% duty cycle. The input clock is taken to run at twice the nominal rate, because the upstream doubler that serves the divide-by-one case lies outside this block. Each output phase therefore lasts `R` input cycles, and the output period is `2*R` input cycles.

A power-down request lowers the output frequency to one sixteenth of the programmed value. It does this in steps rather than all at once. A sequencer, clocked by a separate slower reference clock, doubles an extra divide factor once per dwell interval (x1, x2, x4, x8, x16). When the request is released, it halves the factor back to x1 in four steps.

The sequencer level crosses into the fast domain as a thermometer code. The output-enable input is synchronised, and it gates whole output periods. The internal counters keep running while the output is disabled, so the clock resumes on its original edge grid. A new ratio code or a new power-down level takes effect only where a new output period begins.

Top module: `outdiv_top`

## Requirements
- R1: With power-down idle, each output phase lasts R fast-clock cycles, where `div_sel` 2'b00 gives R=2, 2'b01 gives R=4, 2'b10 gives R=8 and 2'b11 gives R=1.
- R2: In every output period the high and low phases have equal length, including the periods that occur while power-down is stepping.
- R3: `div_sel` is sampled only at the rising edge of `clk_out` that starts a period. A change made during a period leaves both phases of that period at the old length.
- R4: While `pwr_down` is high, the extra divide factor rises through 1, 2, 4, 8 and 16 in that order. It then holds at 16, so each phase lasts 16*R cycles.
- R5: After `pwr_down` falls, the factor returns through 8, 4, 2 and 1, which is four discrete steps, to the programmed frequency.
- R6: Successive level changes are at least STEP_CYC `clk_ref` cycles apart. The first change comes no earlier than STEP_CYC `clk_ref` cycles after the request is seen.
- R7: While `out_en` is low, `clk_out` is held low. Enable changes apply only at period starts, so only whole pulses appear. Counting continues while the output is disabled, so rising edges after re-enable fall on the same grid as before.
- R8: While `rst_n` is low (synchronous), `clk_out` is low and the power-down level is 0. After reset, the output runs at the programmed ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast input clock (twice the nominal rate) |
| clk_ref | input | 1 | Slow reference clock that times the power-down steps |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| div_sel | input | 2 | Ratio code: 00 gives /2, 01 gives /4, 10 gives /8, 11 gives /1 |
| pwr_down | input | 1 | Request to step the output down to one sixteenth of its frequency |
| out_en | input | 1 | Active-high output enable |
| clk_out | output | 1 | Divided output clock, 50% duty cycle |

## Verification
The assertions check several invariants on every cycle:
- the phase length stays fixed within a period, and the phase counter stays inside its range;
- the output changes only together with the internal phase flop;
- an output disabled for long enough stays low;
- in the reference domain, the level moves by one step at most and never before its dwell interval has elapsed.

Only the bench scenarios can show the other behaviours. These are the mapping from code to ratio, the order of the step-down and step-up sequences as seen on the output, the deferral of a code change to the next period, and the return of the output onto its original edge grid after re-enable.

// File: rtl/outdiv_pkg.sv
// Shared definitions for the output divider: ratio codes and their
// power-of-two shift amounts. Assumes every ratio is a power of two.
package outdiv_pkg;

    typedef enum logic [1:0] {
        DIV_BY2 = 2'b00,
        DIV_BY4 = 2'b01,
        DIV_BY8 = 2'b10,
        DIV_BY1 = 2'b11
    } div_code_e;

    // Largest shift any ratio code produces (divide by 8).
    localparam int CODE_SHIFT_MAX = 3;

    // Map a ratio code to log2 of its phase length.
    function automatic logic [1:0] code_shift(input logic [1:0] code);
        case (div_code_e'(code))
            DIV_BY2: return 2'd1;
            DIV_BY4: return 2'd2;
            DIV_BY8: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/outdiv_sync.sv
// Multi-stage synchroniser for a bus whose bits may be sampled one
// at a time. It assumes at most one bit changes between samples
// (thermometer or single-bit signals), so no bus coherency is needed.
module outdiv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/outdiv_pd_seq.sv
// Power-down sequencer in the reference domain. It holds the extra
// divide level as a thermometer code (bit count = level, 0..PD_STEPS)
// and moves it one step toward the request after each full dwell of
// STEP_CYC reference cycles. Assumes pd_req is already synchronised.
module outdiv_pd_seq #(
    parameter int PD_STEPS = 4,
    parameter int STEP_CYC = 8
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic                pd_req,
    output logic [PD_STEPS-1:0] therm
);

    localparam int DW_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [DW_W-1:0] DWELL_LAST = DW_W'(STEP_CYC - 1);

    logic [DW_W-1:0] dwell;
    logic            at_top;
    logic            at_bot;
    logic            want_up;
    logic            want_dn;

    // Decide whether the level must still move, and in which direction.
    always_comb begin
        at_top  = &therm;
        at_bot  = ~|therm;
        want_up = pd_req && !at_top;
        want_dn = !pd_req && !at_bot;
    end

    // Count the dwell and shift the thermometer by one position per step.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            therm <= '0;
            dwell <= '0;
        end else if (want_up || want_dn) begin
            if (dwell == DWELL_LAST) begin
                dwell <= '0;
                if (want_up) therm <= {therm[PD_STEPS-2:0], 1'b1};
                else         therm <= {1'b0, therm[PD_STEPS-1:1]};
            end else begin
                dwell <= dwell + 1'b1;
            end
        end else begin
            dwell <= '0;
        end
    end

endmodule

// File: rtl/outdiv_core.sv
// Fast-domain divider. It toggles a phase flop every 2^half_sh input
// cycles. The shift (ratio code plus power-down level) and the enable
// are loaded only at the edge that starts a new period, so both phases
// of a period always match and no partial pulse appears.
// Assumes div_sel is stable around period starts.
module outdiv_core #(
    parameter int PD_STEPS = 4
) (
    input  logic                clk_fast,
    input  logic                rst_n,
    input  logic [1:0]          div_sel,
    input  logic [$clog2(PD_STEPS+1)-1:0] pd_level,
    input  logic                en_req,
    output logic                clk_out,
    output logic                phase,
    output logic [outdiv_pkg::CODE_SHIFT_MAX+PD_STEPS-1:0] cnt,
    output logic [$clog2(outdiv_pkg::CODE_SHIFT_MAX+PD_STEPS+1)-1:0] half_sh
);

    localparam int MAX_SHIFT = outdiv_pkg::CODE_SHIFT_MAX + PD_STEPS;
    localparam int CNT_W     = MAX_SHIFT;
    localparam int SH_W      = $clog2(MAX_SHIFT + 1);

    logic [SH_W-1:0]  req_sh;
    logic [CNT_W:0]   half_full;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    // Build the requested shift and the terminal count of the current phase.
    always_comb begin
        req_sh    = SH_W'(outdiv_pkg::code_shift(div_sel)) + SH_W'(pd_level);
        half_full = (CNT_W+1)'(1) << half_sh;
        half_m1   = CNT_W'(half_full - 1'b1);
        wrap      = (cnt == half_m1);
    end

    // Advance the phase counter, toggle the phase, load settings at period start.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            cnt     <= '0;
            phase   <= 1'b0;
            clk_out <= 1'b0;
            half_sh <= req_sh;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
            if (!phase) begin
                half_sh <= req_sh;
                clk_out <= en_req;
            end else begin
                clk_out <= 1'b0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/outdiv_top.sv
// Top of the output divider. The power-down request crosses into the
// reference domain, the sequencer steps a thermometer level, and that
// level plus the output enable cross into the fast domain for the core.
// rst_n must be held low for several cycles of both clocks.
module outdiv_top #(
    parameter int PD_STEPS    = 4,
    parameter int STEP_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_fast,
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       pwr_down,
    input  logic       out_en,
    output logic       clk_out
);

    localparam int MAX_SHIFT = outdiv_pkg::CODE_SHIFT_MAX + PD_STEPS;
    localparam int LVL_W     = $clog2(PD_STEPS + 1);
    localparam int SH_W      = $clog2(MAX_SHIFT + 1);

    logic                 pd_req_ref;
    logic [PD_STEPS-1:0]  therm_ref;
    logic [PD_STEPS-1:0]  therm_fast;
    logic                 en_fast;
    logic [LVL_W-1:0]     pd_level;
    logic                 core_phase;
    logic [MAX_SHIFT-1:0] core_cnt;
    logic [SH_W-1:0]      core_half_sh;

    outdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(clk_ref), .rst_n(rst_n), .d(pwr_down), .q(pd_req_ref)
    );

    outdiv_pd_seq #(.PD_STEPS(PD_STEPS), .STEP_CYC(STEP_CYC)) u_seq (
        .clk_ref(clk_ref), .rst_n(rst_n), .pd_req(pd_req_ref), .therm(therm_ref)
    );

    outdiv_sync #(.WIDTH(PD_STEPS), .STAGES(SYNC_STAGES)) u_lvl_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(therm_ref), .q(therm_fast)
    );

    outdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_en_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(out_en), .q(en_fast)
    );

    // Turn the synchronised thermometer code into a level count.
    always_comb begin
        pd_level = '0;
        for (int i = 0; i < PD_STEPS; i++) pd_level = pd_level + LVL_W'(therm_fast[i]);
    end

    outdiv_core #(.PD_STEPS(PD_STEPS)) u_core (
        .clk_fast(clk_fast), .rst_n(rst_n), .div_sel(div_sel), .pd_level(pd_level),
        .en_req(en_fast), .clk_out(clk_out), .phase(core_phase),
        .cnt(core_cnt), .half_sh(core_half_sh)
    );

endmodule

// File: rtl/outdiv_chk.sv
// Assertion checker for outdiv_top, attached by bind. It watches the
// core phase state in the fast domain and the sequencer level in the
// reference domain. Windows that depend on parameters use counters.
module outdiv_chk #(
    parameter int PD_STEPS    = 4,
    parameter int STEP_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                clk_fast,
    input logic                clk_ref,
    input logic                rst_n,
    input logic                out_en,
    input logic                clk_out,
    input logic                phase,
    input logic [outdiv_pkg::CODE_SHIFT_MAX+PD_STEPS-1:0] cnt,
    input logic [$clog2(outdiv_pkg::CODE_SHIFT_MAX+PD_STEPS+1)-1:0] half_sh,
    input logic [PD_STEPS-1:0] pd_therm
);

    localparam int MAX_SHIFT = outdiv_pkg::CODE_SHIFT_MAX + PD_STEPS;
    localparam int OFF_LIMIT = SYNC_STAGES + 2 * (1 << MAX_SHIFT) + 2;

    logic [15:0]         off_cnt;
    logic [15:0]         gap;
    logic [PD_STEPS-1:0] therm_d;
    logic                at_start;

    // Count how long out_en has been low.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)      off_cnt <= '0;
        else if (out_en) off_cnt <= '0;
        else if (off_cnt != 16'hFFFF) off_cnt <= off_cnt + 1'b1;
    end

    // Count reference cycles since the last level change.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            gap     <= '0;
            therm_d <= '0;
        end else begin
            therm_d <= pd_therm;
            if (pd_therm != therm_d)  gap <= '0;
            else if (gap != 16'hFFFF) gap <= gap + 1'b1;
        end
    end

    assign at_start = (cnt == MAX_SHIFT'(((1 << half_sh) - 1))) && !phase;

    // R2
    half_stable_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !at_start |=> $stable(half_sh));

    // R1
    cnt_range_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (32'(cnt) <= ((1 << half_sh) - 1)));

    // R7
    edge_with_phase_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(clk_out) |-> !$stable(phase));

    // R7
    disabled_low_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (32'(off_cnt) > OFF_LIMIT) |-> !clk_out);

    // R6
    one_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(pd_therm ^ therm_d) <= 1);

    // R6
    dwell_gap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (pd_therm != therm_d) |-> (32'(gap) >= STEP_CYC - 1));

endmodule

bind outdiv_top outdiv_chk #(
    .PD_STEPS(PD_STEPS), .STEP_CYC(STEP_CYC), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n), .out_en(out_en),
    .clk_out(clk_out), .phase(core_phase), .cnt(core_cnt),
    .half_sh(core_half_sh), .pd_therm(therm_ref)
);

// File: tb/tb_outdiv_top.sv
`timescale 1ns/100ps
module tb_outdiv_top;

    localparam int PD_STEPS    = 4;
    localparam int STEP_CYC    = 8;
    localparam int SYNC_STAGES = 2;
    localparam int REF_NS      = 42;
    localparam int LIMIT       = 700;

    logic       clk_fast = 1'b0;
    logic       clk_ref  = 1'b0;
    logic       rst_n;
    logic [1:0] div_sel;
    logic       pwr_down;
    logic       out_en;
    logic       clk_out;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    outdiv_top #(.PD_STEPS(PD_STEPS), .STEP_CYC(STEP_CYC), .SYNC_STAGES(SYNC_STAGES)) dut (
        .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n), .div_sel(div_sel),
        .pwr_down(pwr_down), .out_en(out_en), .clk_out(clk_out)
    );

    always #4 clk_fast = ~clk_fast;
    always #(REF_NS/2) clk_ref = ~clk_ref;
    always @(posedge clk_fast) cyc <= cyc + 1;

    function automatic int exp_half(input logic [1:0] code, input int lvl);
        int b;
        case (code)
            2'b00:   b = 2;
            2'b01:   b = 4;
            2'b10:   b = 8;
            default: b = 1;
        endcase
        return b << lvl;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Move to the first negedge sample where clk_out has just risen.
    task automatic sync_rise();
        int n = 0;
        @(negedge clk_fast);
        while (clk_out && n < LIMIT) begin @(negedge clk_fast); n++; end
        while (!clk_out && n < LIMIT) begin @(negedge clk_fast); n++; end
    endtask

    // Measure one period from a rise sample; ends on the next rise sample.
    task automatic measure(output int hi, output int lo);
        hi = 0;
        while (clk_out && hi < LIMIT) begin hi++; @(negedge clk_fast); end
        lo = 0;
        while (!clk_out && lo < LIMIT) begin lo++; @(negedge clk_fast); end
    endtask

    // Follow periods until final_half holds; collect distinct phase lengths.
    task automatic track(input int final_half, output int seq [8], output int nseq,
                         output int t_final);
        int hi, lo, stable, elapsed;
        nseq = 0; stable = 0; elapsed = 0; t_final = -1;
        for (int i = 0; i < 8; i++) seq[i] = 0;
        for (int k = 0; k < 300 && stable < 3; k++) begin
            measure(hi, lo);
            check(hi == lo, "R2 duty during stepping", lo, hi);
            if (nseq == 0 || seq[(nseq > 8 ? 8 : nseq) - 1] != hi) begin
                if (nseq < 8) seq[nseq] = hi;
                nseq++;
            end
            if (hi == final_half) begin
                if (t_final < 0) t_final = elapsed;
                stable++;
            end
            elapsed += hi + lo;
        end
    endtask

    task automatic steady(input logic [1:0] code, input int lvl, input string req);
        int hi, lo;
        sync_rise();
        measure(hi, lo);
        check(hi == exp_half(code, lvl), req, hi, exp_half(code, lvl));
        check(lo == exp_half(code, lvl), "R2 low phase", lo, exp_half(code, lvl));
    endtask

    initial begin
        repeat (150000) @(posedge clk_fast);
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        errors++;
        checks++;
        finish_run();
    end

    initial begin
        int hi, lo, c1, c2, highs, nseq, t_final, lvl_min;
        int seq [8];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; div_sel = 2'b00; pwr_down = 1'b0; out_en = 1'b1;

        // R8: output low during reset
        repeat (20) @(posedge clk_ref);
        highs = 0;
        repeat (30) begin @(negedge clk_fast); if (clk_out) highs++; end
        check(highs == 0, "R8 low in reset", highs, 0);
        @(negedge clk_fast);
        rst_n = 1'b1;
        steady(2'b00, 0, "R8 ratio after reset");

        // R1: every code, directed
        for (int c = 0; c < 4; c++) begin
            @(negedge clk_fast);
            div_sel = 2'(c);
            repeat (40) @(negedge clk_fast);
            steady(2'(c), 0, "R1 directed code");
        end

        // R1/R2: random codes
        for (int k = 0; k < 12; k++) begin
            logic [1:0] code;
            code = 2'($urandom_range(0, 3));
            @(negedge clk_fast);
            div_sel = code;
            repeat (40 + $urandom_range(0, 7)) @(negedge clk_fast);
            steady(code, 0, "R1 random code");
        end

        // R3: change from /8 to /2 just after a rise
        @(negedge clk_fast); div_sel = 2'b10;
        repeat (40) @(negedge clk_fast);
        sync_rise();
        div_sel = 2'b00;
        measure(hi, lo);
        check(hi == 8, "R3 high phase keeps old ratio", hi, 8);
        check(lo == 8, "R3 low phase keeps old ratio", lo, 8);
        measure(hi, lo);
        check(hi == 2 && lo == 2, "R3 next period uses new ratio", hi, 2);

        // R7: disable, stay low, resume on the same grid
        @(negedge clk_fast); div_sel = 2'b01;
        repeat (40) @(negedge clk_fast);
        sync_rise();
        c1 = cyc;
        out_en = 1'b0;
        repeat (60) @(negedge clk_fast);
        highs = 0;
        repeat (200) begin @(negedge clk_fast); if (clk_out) highs++; end
        check(highs == 0, "R7 disabled output low", highs, 0);
        out_en = 1'b1;
        sync_rise();
        c2 = cyc;
        check(((c2 - c1) % 8) == 0, "R7 edge grid kept", (c2 - c1) % 8, 0);
        measure(hi, lo);
        check(hi == 4 && lo == 4, "R7 full pulses after enable", hi, 4);

        // R4/R6: step down at /1
        @(negedge clk_fast); div_sel = 2'b11;
        repeat (40) @(negedge clk_fast);
        sync_rise();
        pwr_down = 1'b1;
        track(16, seq, nseq, t_final);
        check(nseq == 5, "R4 number of levels on entry", nseq, 5);
        for (int i = 0; i < 5; i++)
            check(seq[i] == (1 << i), "R4 entry order", seq[i], 1 << i);
        lvl_min = (PD_STEPS * STEP_CYC * REF_NS) / 8;
        check(t_final >= lvl_min, "R6 dwell before full power-down", t_final, lvl_min);

        // R5: release in four steps
        pwr_down = 1'b0;
        track(1, seq, nseq, t_final);
        check(nseq == 5, "R5 number of levels on release", nseq, 5);
        for (int i = 0; i < 5; i++)
            check(seq[i] == (16 >> i), "R5 release order", seq[i], 16 >> i);

        // R4: steady full power-down at /2 and at /8 (largest phase)
        @(negedge clk_fast); div_sel = 2'b00; pwr_down = 1'b1;
        repeat (800) @(negedge clk_fast);
        steady(2'b00, 4, "R4 /2 with power-down");
        @(negedge clk_fast); div_sel = 2'b10;
        repeat (600) @(negedge clk_fast);
        steady(2'b10, 4, "R4 /8 with power-down");
        @(negedge clk_fast); pwr_down = 1'b0;
        repeat (1500) @(negedge clk_fast);
        steady(2'b10, 0, "R5 back to programmed ratio");

        finish_run();
    end

endmodule